// File: doc/BRIEF.md
# GPIO Output/Enable Register Bank with Atomic Alias Windows

This block holds one bank of general-purpose pin state: an output-level register and a drive-enable register, each one bit per pin, plus a read-only view of the pin inputs taken through a two-flop synchronizer. Software reaches it over a simple valid/ready register bus. Bit n of every register always belongs to pin n. The bank width is a parameter of at most 32 pins.

Each writable register can be reached through four address windows. The plain window replaces the register contents. The other three windows treat the written word as a mask. One toggles the masked bits, one sets them and one clears them. A single pin's level or direction can therefore change in one bus write, without a read-modify-write sequence that could race another agent.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset both the output-level and drive-enable registers read zero, so every pin is an undriven input (`pin_out` and `pin_oe` are all zero).
- R2: Address bits [13:12] pick the window: 0 plain write, 1 toggle (XOR), 2 set (OR), 3 clear (AND-NOT). Address bits [3:2] pick the register: 0 output level, 1 drive enable, 2 input status. Other register selects are ignored on write and read as zero.
- R3: A plain-window write replaces the addressed register with the low WIDTH bits of the write data.
- R4: A toggle-window write inverts exactly the register bits whose mask bit is one and leaves the rest unchanged.
- R5: A set-window write forces the masked bits to one and leaves the rest unchanged.
- R6: A clear-window write forces the masked bits to zero and leaves the rest unchanged.
- R7: A one bit in the drive-enable register makes pin n drive `pin_out[n]`. A zero bit makes it an input. `pin_oe` and `pin_out` reflect the registers one cycle after the accepted write.
- R8: Writes to the input-status register in any window change no register.
- R9: A read through any window returns the plain contents of the addressed register, zero-extended to 32 bits, in the cycle after the accepted request, with `rsp_valid` high for exactly one cycle.
- R10: `pin_in` reaches the input-status register after two clock edges of synchronization.
- R11: The bus accepts one request per cycle (`req_ready` is high whenever out of reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address (window in [13:12], register in [3:2]) |
| req_wdata | input | 32 | Write data or mask |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Pin output levels |
| pin_oe | output | WIDTH | Pin drive enables |

## Verification
The bench sweeps every window against every register with masks chosen so that each window's result differs from every other window's result. A design that swapped the set and toggle operations, or that applied the mask to the wrong register, therefore produces a distinct wrong value. Reads are taken through all four windows to catch a design that returns a mask-modified value instead of the plain contents. Writes to the input-status register are followed by reads of both real registers to confirm nothing moved. The input path is checked at its exact latency: a design with one or three flops in the synchronizer shows the new level a cycle early or late.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  typedef enum logic [1:0] {
    WIN_PLAIN = 2'd0,
    WIN_FLIP  = 2'd1,
    WIN_SET   = 2'd2,
    WIN_CLR   = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    SEL_LEVEL  = 2'd0,
    SEL_DRIVE  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;

  localparam int WIN_LSB = 12;
  localparam int SEL_LSB = 2;

  function automatic logic [31:0] alias_apply(input win_e w, input logic [31:0] cur,
                                              input logic [31:0] msk);
    case (w)
      WIN_PLAIN: alias_apply = msk;
      WIN_FLIP:  alias_apply = cur ^ msk;
      WIN_SET:   alias_apply = cur | msk;
      default:   alias_apply = cur & ~msk;
    endcase
  endfunction
endpackage

// File: rtl/gpio_alias_decode.sv
module gpio_alias_decode
  import gpio_alias_pkg::*;
(
  input  logic [15:0] addr,
  output win_e        win,
  output sel_e        sel
);
  assign win = win_e'(addr[WIN_LSB +: 2]);
  assign sel = sel_e'(addr[SEL_LSB +: 2]);
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  win_e             win,
  input  logic [31:0]      mask,
  output logic [WIDTH-1:0] q
);
  logic [31:0] cur_ext;
  logic [31:0] nxt_ext;
  assign cur_ext = 32'(q);
  assign nxt_ext = alias_apply(win, cur_ext, mask);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= nxt_ext[WIDTH-1:0];
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  win_e win;
  sel_e sel;
  logic acc_wr, acc_rd;
  logic wr_level, wr_drive;
  logic [WIDTH-1:0] level_q, drive_q, status_q;
  logic [31:0] rd_mux;

  gpio_alias_decode u_dec (.addr(req_addr), .win(win), .sel(sel));

  assign req_ready = rst_n;
  assign acc_wr   = req_valid && req_ready && req_write;
  assign acc_rd   = req_valid && req_ready && !req_write;
  assign wr_level = acc_wr && (sel == SEL_LEVEL);
  assign wr_drive = acc_wr && (sel == SEL_DRIVE);

  gpio_alias_reg #(.WIDTH(WIDTH)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_level), .win(win), .mask(req_wdata), .q(level_q));
  gpio_alias_reg #(.WIDTH(WIDTH)) u_drive (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_drive), .win(win), .mask(req_wdata), .q(drive_q));
  gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(status_q));

  always_comb begin
    case (sel)
      SEL_LEVEL:  rd_mux = 32'(level_q);
      SEL_DRIVE:  rd_mux = 32'(drive_q);
      SEL_STATUS: rd_mux = 32'(status_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rd_mux;
    end
  end

  assign pin_out = level_q;
  assign pin_oe  = drive_q;
endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [15:0]      req_addr,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  logic idle_or_status;
  assign idle_or_status = !(req_valid && req_write) || req_addr[3:2] == 2'd2 || req_addr[3:2] == 2'd3;

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  p_rsp_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_rsp_only_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_or_status |=> ($stable(pin_out) && $stable(pin_oe)));

  p_set_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[13:12] == 2'd2 && req_addr[3:2] == 2'd0)
      |=> ((pin_out & $past(req_wdata[WIDTH-1:0])) == $past(req_wdata[WIDTH-1:0])));

  p_clr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[13:12] == 2'd3 && req_addr[3:2] == 2'd1)
      |=> ((pin_oe & $past(req_wdata[WIDTH-1:0])) == '0));
endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/gpio_alias_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_alias_bank_tb_top;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ready, rsp_valid;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic [W-1:0] pin_in = 0, pin_out, pin_oe;
  int checks = 0, fails = 0;
  logic [W-1:0] mdl [2];

  always #4 clk = ~clk;

  gpio_alias_bank #(.WIDTH(W)) dut_i (.*);

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: timeout actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(int w, logic [W-1:0] c, logic [W-1:0] m);
    if (w == 0) return m;
    if (w == 1) return (c & ~m) | (~c & m);
    if (w == 2) return c | m;
    return c & (m ^ {W{1'b1}});
  endfunction

  task automatic wr(int win, int sel, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'(win * 4096 + sel * 4); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(int win, int sel, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'(win * 4096 + sel * 4);
    @(negedge clk);
    req_valid = 0;
    if (rsp_valid !== 1'b1) begin checks++; fails++;
      $display("FAIL R9 rsp_valid actual=%b expected=1", rsp_valid); end
    d = rsp_rdata;
    @(negedge clk);
    chk("R9 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    chk("R1 out", 32'(pin_out), 0);
    chk("R1 oe", 32'(pin_oe), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 ready", 32'(req_ready), 1);
    mdl[0] = 0; mdl[1] = 0;
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 4; w++) begin
        for (int k = 0; k < 4; k++) begin
          logic [W-1:0] m;
          m = W'(8'h5A ^ (8'h33 * k) ^ (w << 4));
          wr(w, s, 32'hFFFF_FF00 | 32'(m));
          mdl[s] = model(w, mdl[s], m);
          chk(w == 0 ? "R3" : w == 1 ? "R4" : w == 2 ? "R5" : "R6",
              32'(s == 0 ? pin_out : pin_oe), 32'(mdl[s]));
          chk("R7 other reg", 32'(s == 0 ? pin_oe : pin_out), 32'(mdl[1-s]));
          rd((k + 1) % 4, s, r);
          chk("R9 read", r, 32'(mdl[s]));
        end
      end
    end
    for (int w = 0; w < 4; w++) begin
      wr(w, 2, 32'hFFFF_FFFF);
      wr(w, 3, 32'hFFFF_FFFF);
      rd(w, 0, r); chk("R8 level", r, 32'(mdl[0]));
      rd(w, 1, r); chk("R8 drive", r, 32'(mdl[1]));
      rd(w, 3, r); chk("R2 unused sel", r, 0);
    end
    // R10: two-edge synchronizer latency
    @(negedge clk); pin_in = 8'hC3;
    @(negedge clk);
    req_valid = 1; req_addr = 16'h0008; req_write = 0;
    @(negedge clk);
    chk("R10 one edge", rsp_rdata, 0);
    @(negedge clk); req_valid = 0;
    chk("R10 two edges", rsp_rdata, 32'hC3);
    for (int w = 0; w < 4; w++) begin
      rd(w, 2, r); chk("R10 status", r, 32'hC3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule